// File: doc/BRIEF.md
# Serial SRAM Slave on an SPI Mode-0 Bus

This block models a byte-wide static memory that a host reaches over a four-wire serial link: a serial clock, an active-low select, a host-to-device data line and a device-to-host data line. A single system clock samples the serial clock, select and data lines through synchronizer flops and finds the edges of the serial clock. Every transaction starts when the select line falls. The first byte of a transaction is an opcode. A memory command then takes three address bytes and moves data bytes into or out of an internal array until the select line rises.

How the internal address advances during a burst depends on a mode register. In single-byte mode, one data byte is moved per address. In page mode, the address cycles within an aligned 32-byte page. In sequential mode, the address steps through the whole array and wraps from the top back to zero. The host writes the mode register with a separate opcode and reads it back with another. The array depth and the page size are parameters.

The state machine has eight states:

- `ST_IDLE`: select is high, or has only just fallen.
- `ST_OPCODE`: the first byte is being collected.
- `ST_ADDR`: the three address bytes are being collected.
- `ST_WRDATA`: bytes are being stored into the array.
- `ST_RDDATA`: bytes are being shifted out of the array.
- `ST_MODE_WR`: the mode byte is being received.
- `ST_MODE_RD`: the mode register is being returned.
- `ST_IGNORE`: the rest of the frame is discarded.

The transitions are as follows:

- Any state goes to `ST_IDLE` while the synchronized select is high.
- `ST_IDLE` goes to `ST_OPCODE` once select is low.
- `ST_OPCODE` decodes its byte:
  - opcode 0x02 or 0x03 goes to `ST_ADDR`;
  - opcode 0x01 goes to `ST_MODE_WR`;
  - opcode 0x05 goes to `ST_MODE_RD`;
  - any other value goes to `ST_IGNORE`.
- `ST_ADDR` goes to `ST_WRDATA` or `ST_RDDATA` after its third byte.
- `ST_WRDATA` and `ST_RDDATA` go to `ST_IGNORE` after one byte in single-byte mode.
- `ST_MODE_WR` goes to `ST_IGNORE` after its byte.

Top module: `spi_sram_model`

## Requirements
- R1: Opcode 0x02, followed by a 24-bit address sent as three bytes (most significant first), stores each following data byte into the array. The first data byte goes to the given address.
- R2: Opcode 0x03, followed by a 24-bit address, returns the stored bytes on `miso`, starting at the given address.
- R3: All bits travel most-significant bit first. `mosi` is taken at the rising edge of `sck`, and `miso` changes only after a falling edge of `sck`. `sck` idles low. Correct operation needs an `sck` period of at least 8 system clock cycles, with each phase at least 4 cycles.
- R4: `miso_oe` is 1 only while select is low and the frame is in the read-data phase or the mode-read phase. Otherwise it is 0, and `miso` is then 0. `miso_oe` is 0 after reset.
- R5: A frame ends only when `cs_n` goes high, and the first byte after `cs_n` falls is always decoded as an opcode. A frame cut short before its address is complete has no effect. An unknown opcode makes the rest of the frame have no effect and keeps `miso_oe` at 0.
- R6: In single-byte mode (mode bits 7:6 = 00), only the first data byte of a read or write frame is transferred. Later bytes in that frame neither write the array nor drive `miso`.
- R7: In page mode (mode bits 7:6 = 10), the address steps through a 32-byte aligned page and wraps to the first byte of that same page. Bytes outside the page are untouched.
- R8: In sequential mode (mode bits 7:6 = 01), the address steps by one through the whole array and wraps from the last address to address 0.
- R9: Opcode 0x01, followed by one byte, loads bits 7:6 of that byte into the mode register. Opcode 0x05 returns a byte with the mode in bits 7:6 and zeros below. The reserved value 11 reads back as 0xC0 and behaves as single-byte mode.
- R10: After reset the mode register selects sequential mode, so a mode read returns 0x40.
- R11: Address bits above the array's address width are ignored, so addresses that differ only in those bits reach the same byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all serial lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock from the host, idles low |
| cs_n | input | 1 | Active-low frame select |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host, 0 when not enabled |
| miso_oe | output | 1 | High when the host should see `miso` driven; low means high impedance |

## Verification
The checker watches the following on every cycle:
- the return to `ST_IDLE` and the clearing of the bit count whenever select is high;
- that `miso` changes only in the cycle after a detected falling edge;
- that single-byte mode leaves the write phase after one stored byte;
- that page-mode writes never cross the page boundary;
- that sequential writes step the address by exactly one.

Only the bench's scenarios can show whole-frame behaviour:
- that data written comes back in order and at the right address;
- the wrap at the top of the array and address aliasing;
- the read-back of mode values, including the reserved one;
- that discarded bytes, unknown opcodes and frames cut short leave the memory as it was.

// File: rtl/spi_sram_pkg.sv
package spi_sram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_ADDR,
        ST_WRDATA,
        ST_RDDATA,
        ST_MODE_WR,
        ST_MODE_RD,
        ST_IGNORE
    } sram_state_t;

    typedef enum logic [1:0] {
        MODE_BYTE = 2'b00,
        MODE_SEQ  = 2'b01,
        MODE_PAGE = 2'b10,
        MODE_RSVD = 2'b11
    } addr_mode_t;

    localparam logic [7:0] OP_MODE_WR = 8'h01;
    localparam logic [7:0] OP_WRITE   = 8'h02;
    localparam logic [7:0] OP_READ    = 8'h03;
    localparam logic [7:0] OP_MODE_RD = 8'h05;

    localparam int ADDR_BYTES = 3;

endpackage

// File: rtl/spi_edge_sync.sv
module spi_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic mosi,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_hi,
    output logic mosi_s
);

    logic [STAGES-1:0] sck_p;
    logic [STAGES-1:0] cs_p;
    logic [STAGES-1:0] mosi_p;
    logic              sck_last;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sck_p  <= '0;
                    cs_p   <= '1;
                    mosi_p <= '0;
                end else begin
                    sck_p  <= sck;
                    cs_p   <= cs_n;
                    mosi_p <= mosi;
                end
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sck_p  <= '0;
                    cs_p   <= '1;
                    mosi_p <= '0;
                end else begin
                    sck_p  <= {sck_p[STAGES-2:0], sck};
                    cs_p   <= {cs_p[STAGES-2:0], cs_n};
                    mosi_p <= {mosi_p[STAGES-2:0], mosi};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sck_last <= 1'b0;
        else        sck_last <= sck_p[STAGES-1];
    end

    assign sck_rise = sck_p[STAGES-1] & ~sck_last;
    assign sck_fall = ~sck_p[STAGES-1] & sck_last;
    assign cs_hi    = cs_p[STAGES-1];
    assign mosi_s   = mosi_p[STAGES-1];

endmodule

// File: rtl/sram_store.sv
module sram_store #(
    parameter int DEPTH = 256,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);

    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/addr_advance.sv
module addr_advance
    import spi_sram_pkg::*;
#(
    parameter int AW = 8,
    parameter int PW = 5
) (
    input  logic [AW-1:0] cur,
    input  addr_mode_t    mode,
    output logic [AW-1:0] nxt
);

    logic [AW-1:0] seq_nxt;
    logic [AW-1:0] page_nxt;

    assign seq_nxt = cur + 1'b1;

    generate
        if (AW > PW) begin : g_page
            logic [PW-1:0] low_nxt;
            assign low_nxt  = cur[PW-1:0] + 1'b1;
            assign page_nxt = {cur[AW-1:PW], low_nxt};
        end else begin : g_flat
            assign page_nxt = seq_nxt;
        end
    endgenerate

    always_comb begin
        unique case (mode)
            MODE_SEQ:  nxt = seq_nxt;
            MODE_PAGE: nxt = page_nxt;
            MODE_BYTE: nxt = cur;
            MODE_RSVD: nxt = cur;
        endcase
    end

endmodule

// File: rtl/spi_sram_model.sv
module spi_sram_model
    import spi_sram_pkg::*;
#(
    parameter int DEPTH       = 256,
    parameter int PAGE_BYTES  = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic mosi,
    output logic miso,
    output logic miso_oe
);

    localparam int AW = $clog2(DEPTH);
    localparam int PW = $clog2(PAGE_BYTES);

    logic sck_rise, sck_fall, cs_hi, mosi_s;

    sram_state_t   st_q, st_d;
    addr_mode_t    mode_q;
    logic [2:0]    bit_q;
    logic [6:0]    sh_q;
    logic [1:0]    abyte_q;
    logic [15:0]   addr_acc_q;
    logic [AW-1:0] addr_q;
    logic [AW-1:0] addr_nxt;
    logic          is_wr_q;
    logic [7:0]    tx_q;
    logic          miso_q;

    logic [7:0]    byte_in;
    logic          byte_done;
    logic [23:0]   full_addr;
    logic [AW-1:0] rd_addr;
    logic [7:0]    rd_data;
    logic          mem_we;
    logic          one_shot;
    logic          tx_phase;

    spi_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck      (sck),
        .cs_n     (cs_n),
        .mosi     (mosi),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .cs_hi    (cs_hi),
        .mosi_s   (mosi_s)
    );

    addr_advance #(.AW(AW), .PW(PW)) u_adv (
        .cur  (addr_q),
        .mode (mode_q),
        .nxt  (addr_nxt)
    );

    assign byte_in   = {sh_q, mosi_s};
    assign byte_done = sck_rise && (bit_q == 3'd7) && !cs_hi;
    assign full_addr = {addr_acc_q, byte_in};
    assign one_shot  = (mode_q == MODE_BYTE) || (mode_q == MODE_RSVD);
    assign rd_addr   = (st_q == ST_ADDR) ? full_addr[AW-1:0] : addr_nxt;
    assign mem_we    = byte_done && (st_q == ST_WRDATA);
    assign tx_phase  = (st_q == ST_RDDATA) || (st_q == ST_MODE_RD);

    sram_store #(.DEPTH(DEPTH)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (addr_q),
        .wdata (byte_in),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // next-state logic
    always_comb begin
        st_d = st_q;
        if (cs_hi) begin
            st_d = ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE:   st_d = ST_OPCODE;
                ST_OPCODE: begin
                    if (byte_done) begin
                        if (byte_in == OP_WRITE || byte_in == OP_READ) st_d = ST_ADDR;
                        else if (byte_in == OP_MODE_WR)                st_d = ST_MODE_WR;
                        else if (byte_in == OP_MODE_RD)                st_d = ST_MODE_RD;
                        else                                           st_d = ST_IGNORE;
                    end
                end
                ST_ADDR: begin
                    if (byte_done && abyte_q == 2'(ADDR_BYTES - 1))
                        st_d = is_wr_q ? ST_WRDATA : ST_RDDATA;
                end
                ST_WRDATA:  if (byte_done && one_shot) st_d = ST_IGNORE;
                ST_RDDATA:  if (byte_done && one_shot) st_d = ST_IGNORE;
                ST_MODE_WR: if (byte_done)             st_d = ST_IGNORE;
                ST_MODE_RD: st_d = ST_MODE_RD;
                ST_IGNORE:  st_d = ST_IGNORE;
            endcase
        end
    end

    // datapath: bit capture, address, mode register, transmit shifter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q      <= '0;
            sh_q       <= '0;
            abyte_q    <= '0;
            addr_acc_q <= '0;
            addr_q     <= '0;
            is_wr_q    <= 1'b0;
            mode_q     <= MODE_SEQ;
            tx_q       <= '0;
            miso_q     <= 1'b0;
        end else if (cs_hi) begin
            bit_q   <= '0;
            abyte_q <= '0;
        end else begin
            if (sck_fall && tx_phase) begin
                miso_q <= tx_q[7];
                tx_q   <= {tx_q[6:0], 1'b0};
            end
            if (sck_rise) begin
                bit_q <= bit_q + 1'b1;
                sh_q  <= byte_in[6:0];
            end
            if (byte_done) begin
                unique case (st_q)
                    ST_OPCODE: begin
                        is_wr_q <= (byte_in == OP_WRITE);
                        abyte_q <= '0;
                        if (byte_in == OP_MODE_RD) tx_q <= {mode_q, 6'b0};
                    end
                    ST_ADDR: begin
                        abyte_q    <= abyte_q + 1'b1;
                        addr_acc_q <= {addr_acc_q[7:0], byte_in};
                        if (abyte_q == 2'(ADDR_BYTES - 1)) begin
                            addr_q <= full_addr[AW-1:0];
                            tx_q   <= rd_data;
                        end
                    end
                    ST_WRDATA: addr_q <= addr_nxt;
                    ST_RDDATA: begin
                        addr_q <= addr_nxt;
                        tx_q   <= rd_data;
                    end
                    ST_MODE_WR: mode_q <= addr_mode_t'(byte_in[7:6]);
                    ST_MODE_RD: tx_q   <= {mode_q, 6'b0};
                    ST_IDLE, ST_IGNORE: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        miso_oe = tx_phase && !cs_hi;
        miso    = miso_oe ? miso_q : 1'b0;
    end

endmodule

// File: rtl/spi_sram_chk.sv
module spi_sram_chk
    import spi_sram_pkg::*;
#(
    parameter int AW = 8,
    parameter int PW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs_hi,
    input logic          sck_fall,
    input sram_state_t   st,
    input addr_mode_t    mode,
    input logic          mem_we,
    input logic [AW-1:0] addr,
    input logic [2:0]    bit_cnt,
    input logic          miso_q
);

    AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        cs_hi |=> (st == ST_IDLE)); // R5

    AST_DESELECT_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        cs_hi |=> (bit_cnt == 3'd0)); // R5

    AST_MISO_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(miso_q) |-> $past(sck_fall)); // R3

    AST_BYTE_MODE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && (mode == MODE_BYTE || mode == MODE_RSVD)) |=> (st == ST_IGNORE)); // R6

    AST_PAGE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mode == MODE_PAGE) |=> (addr[AW-1:PW] == $past(addr[AW-1:PW]))); // R7

    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mode == MODE_SEQ) |=> (addr == AW'($past(addr) + 1'b1))); // R8

endmodule

bind spi_sram_model spi_sram_chk #(.AW(AW), .PW(PW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_hi    (cs_hi),
    .sck_fall (sck_fall),
    .st       (st_q),
    .mode     (mode_q),
    .mem_we   (mem_we),
    .addr     (addr_q),
    .bit_cnt  (bit_q),
    .miso_q   (miso_q)
);

// File: tb/spi_sram_model_test.sv
`timescale 1ns/1ps
module spi_sram_model_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0;
    logic cs_n = 1'b1;
    logic mosi = 1'b0;
    logic miso, miso_oe;

    always #2.5 clk = ~clk;

    spi_sram_model uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .sck     (sck),
        .cs_n    (cs_n),
        .mosi    (mosi),
        .miso    (miso),
        .miso_oe (miso_oe)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int r3_bad   = 0;
    bit finished = 0;

    logic [7:0] exp_val[$];
    string      exp_tag[$];
    logic [7:0] got_val[$];
    event       got_ev;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic expect_byte(input logic [7:0] v, input string tag);
        exp_val.push_back(v);
        exp_tag.push_back(tag);
    endtask

    // monitor: pops results as they arrive and compares with the scoreboard
    initial begin
        forever begin
            @(got_ev);
            while (got_val.size() > 0) begin
                logic [7:0] g;
                g = got_val.pop_front();
                if (exp_val.size() == 0) begin
                    check(1'b0, "R2 unexpected byte", g, 0);
                end else begin
                    logic [7:0] e;
                    string t;
                    e = exp_val.pop_front();
                    t = exp_tag.pop_front();
                    check(g === e, t, g, e);
                end
            end
        end
    end

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx,
                        output logic oe_any, output logic oe_all);
        logic pre;
        rx = '0; oe_any = 1'b0; oe_all = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            mosi = tx[i];
            repeat (4) @(negedge clk);
            rx[i]  = miso;
            pre    = miso;
            oe_any = oe_any | miso_oe;
            oe_all = oe_all & miso_oe;
            sck = 1'b1;
            repeat (2) @(negedge clk);
            if (miso_oe && miso !== pre) r3_bad++;
            repeat (2) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    task automatic sel();
        @(negedge clk);
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic desel();
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] b);
        logic [7:0] r; logic a, l;
        xfer(b, r, a, l);
    endtask

    task automatic header(input logic [7:0] op, input logic [23:0] a);
        send(op);
        send(a[23:16]);
        send(a[15:8]);
        send(a[7:0]);
    endtask

    task automatic write_mem(input logic [23:0] a, input int n,
                             input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2);
        sel();
        header(8'h02, a);
        send(b0);
        if (n > 1) send(b1);
        if (n > 2) send(b2);
        desel();
    endtask

    task automatic read_mem(input logic [23:0] a, input int n, input string tag);
        logic [7:0] r; logic any, all;
        sel();
        header(8'h03, a);
        for (int i = 0; i < n; i++) begin
            xfer(8'h00, r, any, all);
            check(all, {tag, " R4 miso_oe during read"}, all, 1);
            got_val.push_back(r);
            -> got_ev;
        end
        desel();
        check(miso_oe == 1'b0, "R4 miso_oe after deselect", miso_oe, 0);
    endtask

    task automatic set_mode(input logic [7:0] v);
        sel();
        send(8'h01);
        send(v);
        desel();
    endtask

    task automatic get_mode();
        logic [7:0] r; logic any, all;
        sel();
        send(8'h05);
        xfer(8'h00, r, any, all);
        got_val.push_back(r);
        -> got_ev;
        desel();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] r; logic any, all;
        repeat (5) @(negedge clk);
        check(miso_oe == 1'b0, "R4 miso_oe in reset", miso_oe, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(miso_oe == 1'b0, "R4 miso_oe after reset", miso_oe, 0);

        // R10: default mode is sequential
        expect_byte(8'h40, "R10 reset mode");
        get_mode();

        // R1/R2: write then read a burst
        write_mem(24'h000010, 3, 8'hA5, 8'h3C, 8'hF0);
        expect_byte(8'hA5, "R1 byte0"); expect_byte(8'h3C, "R1 byte1"); expect_byte(8'hF0, "R2 byte2");
        read_mem(24'h000010, 3, "R2");

        // R8: sequential wrap at the top of the array
        write_mem(24'h0000FF, 2, 8'h11, 8'h22, 8'h00);
        expect_byte(8'h11, "R8 top"); expect_byte(8'h22, "R8 wrapped");
        read_mem(24'h0000FF, 2, "R8");
        expect_byte(8'h22, "R8 addr0");
        read_mem(24'h000000, 1, "R8");

        // R11: upper address bits are ignored
        expect_byte(8'h11, "R11 alias read");
        read_mem(24'h0300FF, 1, "R11");
        write_mem(24'h7F0020, 1, 8'h5A, 8'h00, 8'h00);
        expect_byte(8'h5A, "R11 alias write");
        read_mem(24'h000020, 1, "R11");

        // seed bytes used by later cases
        write_mem(24'h000050, 2, 8'h01, 8'h02, 8'h00);
        write_mem(24'h000060, 2, 8'h03, 8'h04, 8'h00);
        write_mem(24'h000040, 1, 8'hEE, 8'h00, 8'h00);

        // R7: page mode wrap inside 0x20..0x3F
        set_mode(8'h80);
        expect_byte(8'h80, "R9 page readback");
        get_mode();
        write_mem(24'h00003E, 3, 8'h77, 8'h88, 8'h99);
        expect_byte(8'h88, "R7 page end"); expect_byte(8'h99, "R7 page start");
        read_mem(24'h00003F, 2, "R7");
        set_mode(8'h40);
        expect_byte(8'h88, "R7 seq check 0x3F"); expect_byte(8'hEE, "R7 next page untouched");
        read_mem(24'h00003F, 2, "R7");

        // R6: single-byte mode
        set_mode(8'h00);
        write_mem(24'h000050, 2, 8'hAB, 8'hCD, 8'h00);
        sel();
        header(8'h03, 24'h000050);
        xfer(8'h00, r, any, all);
        check(r == 8'hAB, "R6 first byte read", r, 8'hAB);
        xfer(8'h00, r, any, all);
        check(any == 1'b0, "R6 second byte miso_oe", any, 0);
        desel();

        // R9: reserved mode reads back and acts as single-byte
        set_mode(8'hFF);
        expect_byte(8'hC0, "R9 reserved readback");
        get_mode();
        write_mem(24'h000060, 2, 8'h12, 8'h34, 8'h00);
        set_mode(8'h40);
        expect_byte(8'hAB, "R6 stored"); expect_byte(8'h02, "R6 second byte ignored");
        read_mem(24'h000050, 2, "R6");
        expect_byte(8'h12, "R9 reserved stored"); expect_byte(8'h04, "R9 reserved one byte");
        read_mem(24'h000060, 2, "R9");

        // R5: unknown opcode ignored, aborted frame, fresh opcode
        sel();
        xfer(8'h9F, r, any, all);
        xfer(8'h02, r, any, all);
        xfer(8'h00, r, any, all);
        check(any == 1'b0, "R5 unknown opcode miso_oe", any, 0);
        desel();
        sel();
        send(8'h02);
        send(8'h00);
        desel();
        expect_byte(8'hA5, "R5 aborted frame no effect");
        read_mem(24'h000010, 1, "R5");
        expect_byte(8'h40, "R5 mode intact");
        get_mode();

        repeat (20) @(negedge clk);
        check(r3_bad == 0, "R3 miso stable during high phase", r3_bad, 0);
        check(exp_val.size() == 0, "R2 all expected bytes seen", exp_val.size(), 0);

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule